// File: doc/BRIEF.md
# Micro-op Steering Queue with Asymmetric Decode Slots

This block sits between an instruction fetch buffer and register rename. Each cycle the fetch side presents up to three instructions in program order. The length and class of each instruction are already known. Each one carries its micro-op count and up to four fully built micro-ops. The block steers these instructions onto three decode slots. Slot 0 is the only slot that can take a multi-micro-op instruction. Slots 1 and 2 take only single-micro-op instructions. The selected micro-ops are written in program order into a six-entry queue, and rename drains up to three entries per cycle from the head of that queue.

Any instruction whose count is above four is not expanded by the decode slots. When it reaches slot 0 it is consumed on its own, and a start pulse with an entry opcode goes to an external microcode sequencer. That sequencer then delivers the micro-op stream one entry per cycle, under a ready/valid handshake, and marks the last entry. Until that last entry has been accepted, the decode slots take nothing.

A micro-op is a packed record made of an opcode and three 32-bit fields: destination, source A and source B. Each of the three fields is wide enough to carry an immediate.

Top module: `uq_steer_queue`

## Requirements
- R1: During and right after reset, the queue is empty (`out_valid` all zero) and the sequencer is idle (`mseq_ready` low).
- R2: An instruction taken at slot 0 with a count c from 1 to 4 writes its micro-ops 0..c-1 into the queue in order. These are followed, in order, by micro-op 0 of each simple instruction taken at slots 1 and 2. Micro-op k of slot s sits at bits `[(s*4+k)*104 +: 104]` of `in_uops`. It is packed as opcode[103:96], destination[95:64], source A[63:32], source B[31:0].
- R3: Slots 1 and 2 accept only count 1. The group ends at the first invalid slot or the first later instruction whose count is not 1. `in_take` reports how many leading instructions were consumed, and no instruction after the stop point is consumed.
- R4: An instruction with a count of 5 to 7 in slot 0 is consumed alone (`in_take` = 1) and writes nothing into the queue. In that same cycle `mseq_start` pulses, with `mseq_entry` equal to the opcode of its micro-op 0.
- R5: An instruction with a count above 4 in slot 1 or 2 ends the group before it. It is then left for slot 0 of a later cycle.
- R6: A group is taken only if the free entries, counted as depth minus occupancy at the start of the cycle, cover all of its micro-ops. Otherwise `in_take` is 0 and nothing is written. Occupancy never exceeds 6.
- R7: From the cycle after `mseq_start` until the cycle after the accepted last sequencer micro-op, `in_take` is 0.
- R8: `mseq_ready` is high exactly when the sequencer is active and the queue has at least one free entry. A sequencer micro-op presented with `mseq_valid` while ready is appended to the queue.
- R9: `out_valid[i]` is set for each i below the occupancy, and `out_uops` entry i holds the i-th oldest micro-op. `rn_pop` removes that many entries from the head at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 3 | Per-slot instruction valid, contiguous from slot 0 |
| in_cnt | input | 9 | Per-slot micro-op count, 3 bits per slot (1..4 decoded, 5..7 microcoded) |
| in_uops | input | 1248 | Pre-built micro-ops, four per slot |
| in_take | output | 2 | Number of leading instructions consumed this cycle |
| mseq_start | output | 1 | Start pulse to the microcode sequencer |
| mseq_entry | output | 8 | Entry opcode for the sequencer |
| mseq_valid | input | 1 | Sequencer micro-op valid |
| mseq_uop | input | 104 | Sequencer micro-op |
| mseq_last | input | 1 | Marks the final sequencer micro-op |
| mseq_ready | output | 1 | Block accepts a sequencer micro-op |
| out_valid | output | 3 | Head entries valid toward rename |
| out_uops | output | 312 | The three oldest queue entries, oldest in the low bits |
| rn_pop | input | 2 | Entries removed by rename this cycle |

## Verification
The assertions rely on four properties of the inputs. `in_valid` is contiguous from slot 0. Every valid count is nonzero. `mseq_valid` is raised only between a start pulse and the accepted last micro-op. `rn_pop` never exceeds the number of set `out_valid` bits. The bench's fetch model presents a linear instruction stream that it advances by the consumed count, so valid slots are always a prefix. Its sequencer model emits exactly the announced number of micro-ops after each start. Its rename model draws `rn_pop` at random but caps it at the reference queue's occupancy and at three.

// File: rtl/uq_pkg.sv
// Shared micro-op record for the steering queue.
// Assumes a single fixed micro-op layout across decode, sequencer and queue.
package uq_pkg;
    localparam int OPC_W = 8;
    localparam int FLD_W = 32;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [FLD_W-1:0] dst;
        logic [FLD_W-1:0] src_a;
        logic [FLD_W-1:0] src_b;
    } uop_t;

    localparam int UOP_W = $bits(uop_t);
endpackage

// File: rtl/uq_steer.sv
// Steering of one fetch group onto asymmetric decode slots.
// Slot 0 handles counts 1..MAXU, or hands a longer instruction to the
// sequencer. Later slots take count-1 instructions only. The whole group
// is dropped when the queue lacks room or the sequencer is busy.
// Assumes in_valid is contiguous from slot 0 and counts are nonzero.
module uq_steer
    import uq_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int MAXU   = 4,
    parameter int CNT_W  = 3,
    parameter int WR_MAX = MAXU + NSLOT - 1,
    parameter int WR_W   = $clog2(WR_MAX + 1),
    parameter int TAKE_W = $clog2(NSLOT + 1),
    parameter int FREE_W = 3
) (
    input  logic              busy,
    input  logic [FREE_W-1:0] free,
    input  logic [NSLOT-1:0]  in_valid,
    input  logic [CNT_W-1:0]  in_cnt [NSLOT],
    input  uop_t              in_uop [NSLOT][MAXU],
    output logic [TAKE_W-1:0] take,
    output logic [WR_W-1:0]   wr_n,
    output uop_t              wr_uop [WR_MAX],
    output logic              mstart,
    output logic [OPC_W-1:0]  mentry
);
    // Walk the slots in program order, building the write list and take count.
    always_comb begin
        logic [WR_W-1:0]   need_v;
        logic [TAKE_W-1:0] tk_v;
        logic              stop_v;
        logic              ms_v;
        need_v = '0;
        tk_v   = '0;
        stop_v = 1'b0;
        ms_v   = 1'b0;
        for (int k = 0; k < WR_MAX; k++) wr_uop[k] = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (stop_v || !in_valid[s]) begin
                stop_v = 1'b1;
            end else if (s == 0) begin
                if (int'(in_cnt[0]) > MAXU) begin
                    ms_v   = 1'b1;
                    tk_v   = TAKE_W'(1);
                    stop_v = 1'b1;
                end else begin
                    for (int k = 0; k < MAXU; k++)
                        if (k < int'(in_cnt[0])) wr_uop[k] = in_uop[0][k];
                    need_v = WR_W'(in_cnt[0]);
                    tk_v   = TAKE_W'(1);
                end
            end else if (int'(in_cnt[s]) == 1) begin
                wr_uop[need_v] = in_uop[s][0];
                need_v = need_v + WR_W'(1);
                tk_v   = tk_v + TAKE_W'(1);
            end else begin
                stop_v = 1'b1;
            end
        end
        if (busy || int'(need_v) > int'(free)) begin
            need_v = '0;
            tk_v   = '0;
            ms_v   = 1'b0;
        end
        take   = tk_v;
        wr_n   = need_v;
        mstart = ms_v;
        mentry = in_uop[0][0].opc;
    end
endmodule

// File: rtl/uq_mseq_ctl.sv
// Tracks whether the external microcode sequencer owns the queue input.
// Assumes the sequencer raises valid only while this block reports busy.
module uq_mseq_ctl #(
    parameter int FREE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mstart,
    input  logic              mseq_valid,
    input  logic              mseq_last,
    input  logic [FREE_W-1:0] free,
    output logic              busy,
    output logic              mready,
    output logic              seq_acc
);
    assign mready  = busy && (free != '0);
    assign seq_acc = mready && mseq_valid;

    // Busy from the cycle after a start until the last micro-op is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                     busy <= 1'b0;
        else if (mstart)                busy <= 1'b1;
        else if (seq_acc && mseq_last)  busy <= 1'b0;
    end
endmodule

// File: rtl/uq_fifo.sv
// Circular queue with up to WR_MAX writes and RD_MAX reads per cycle.
// Assumes the writer never exceeds the free space and the reader never
// pops more than the valid head entries. Depth need not be a power of two.
module uq_fifo
    import uq_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int WR_MAX = 6,
    parameter int RD_MAX = 3,
    parameter int WR_W   = $clog2(WR_MAX + 1),
    parameter int RD_W   = $clog2(RD_MAX + 1),
    parameter int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WR_W-1:0]  wr_n,
    input  uop_t             wr_data [WR_MAX],
    input  logic [RD_W-1:0]  rd_n,
    output logic [RD_MAX-1:0] rd_valid,
    output uop_t             rd_data [RD_MAX],
    output logic [OCC_W-1:0] occ
);
    localparam int PTR_W = $clog2(DEPTH);

    uop_t             mem [DEPTH];
    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] tail;

    function automatic logic [PTR_W-1:0] adv(logic [PTR_W-1:0] p, int n);
        return PTR_W'((int'(p) + n) % DEPTH);
    endfunction

    // Store the incoming micro-ops at consecutive slots after the tail.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WR_MAX; i++)
            if (i < int'(wr_n)) mem[adv(tail, i)] <= wr_data[i];
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            head <= adv(head, int'(rd_n));
            tail <= adv(tail, int'(wr_n));
            occ  <= occ + OCC_W'(wr_n) - OCC_W'(rd_n);
        end
    end

    for (genvar g = 0; g < RD_MAX; g++) begin : g_rd
        assign rd_data[g]  = mem[adv(head, g)];
        assign rd_valid[g] = int'(occ) > g;
    end
endmodule

// File: rtl/uq_steer_queue.sv
// Top of the micro-op steering queue: decode-slot steering, sequencer
// hand-off and the micro-op queue toward rename.
// Assumes the group, sequencer and pop inputs obey the rules in the brief.
module uq_steer_queue
    import uq_pkg::*;
#(
    parameter int NSLOT = 3,
    parameter int MAXU  = 4,
    parameter int CNT_W = 3,
    parameter int DEPTH = 6,
    parameter int DRAIN = 3,
    localparam int TAKE_W = $clog2(NSLOT + 1),
    localparam int POP_W  = $clog2(DRAIN + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSLOT-1:0]             in_valid,
    input  logic [NSLOT*CNT_W-1:0]       in_cnt,
    input  logic [NSLOT*MAXU*UOP_W-1:0]  in_uops,
    output logic [TAKE_W-1:0]            in_take,
    output logic                         mseq_start,
    output logic [OPC_W-1:0]             mseq_entry,
    input  logic                         mseq_valid,
    input  logic [UOP_W-1:0]             mseq_uop,
    input  logic                         mseq_last,
    output logic                         mseq_ready,
    output logic [DRAIN-1:0]             out_valid,
    output logic [DRAIN*UOP_W-1:0]       out_uops,
    input  logic [POP_W-1:0]             rn_pop
);
    localparam int WR_MAX = MAXU + NSLOT - 1;
    localparam int WR_W   = $clog2(WR_MAX + 1);
    localparam int OCC_W  = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt_a [NSLOT];
    uop_t             uop_a [NSLOT][MAXU];
    logic [WR_W-1:0]  st_wr_n;
    uop_t             st_wr [WR_MAX];
    logic [WR_W-1:0]  q_wr_n;
    uop_t             q_wr [WR_MAX];
    uop_t             q_rd [DRAIN];
    logic [OCC_W-1:0] occ;
    logic [OCC_W-1:0] free;
    logic             busy;
    logic             seq_acc;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign cnt_a[s] = in_cnt[s*CNT_W +: CNT_W];
        for (genvar k = 0; k < MAXU; k++) begin : g_u
            assign uop_a[s][k] = in_uops[(s*MAXU+k)*UOP_W +: UOP_W];
        end
    end

    assign free = OCC_W'(DEPTH) - occ;

    uq_steer #(
        .NSLOT(NSLOT), .MAXU(MAXU), .CNT_W(CNT_W), .WR_MAX(WR_MAX),
        .WR_W(WR_W), .TAKE_W(TAKE_W), .FREE_W(OCC_W)
    ) u_steer (
        .busy(busy), .free(free), .in_valid(in_valid), .in_cnt(cnt_a),
        .in_uop(uop_a), .take(in_take), .wr_n(st_wr_n), .wr_uop(st_wr),
        .mstart(mseq_start), .mentry(mseq_entry)
    );

    uq_mseq_ctl #(.FREE_W(OCC_W)) u_mseq (
        .clk(clk), .rst_n(rst_n), .mstart(mseq_start),
        .mseq_valid(mseq_valid), .mseq_last(mseq_last), .free(free),
        .busy(busy), .mready(mseq_ready), .seq_acc(seq_acc)
    );

    // Choose the queue write source: sequencer while busy, decode otherwise.
    always_comb begin
        if (busy) begin
            for (int k = 0; k < WR_MAX; k++) q_wr[k] = '0;
            q_wr[0] = mseq_uop;
            q_wr_n  = seq_acc ? WR_W'(1) : '0;
        end else begin
            q_wr   = st_wr;
            q_wr_n = st_wr_n;
        end
    end

    uq_fifo #(
        .DEPTH(DEPTH), .WR_MAX(WR_MAX), .RD_MAX(DRAIN),
        .WR_W(WR_W), .RD_W(POP_W), .OCC_W(OCC_W)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_n(q_wr_n), .wr_data(q_wr),
        .rd_n(rn_pop), .rd_valid(out_valid), .rd_data(q_rd), .occ(occ)
    );

    for (genvar g = 0; g < DRAIN; g++) begin : g_out
        assign out_uops[g*UOP_W +: UOP_W] = q_rd[g];
    end
endmodule

// File: rtl/uq_chk.sv
// Protocol checker for uq_steer_queue, attached by bind.
// Assumes the input rules listed in the brief's verification section.
module uq_chk #(
    parameter int NSLOT = 3,
    parameter int DEPTH = 6,
    parameter int DRAIN = 3,
    localparam int TAKE_W = $clog2(NSLOT + 1),
    localparam int OCC_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSLOT-1:0]  in_valid,
    input logic [TAKE_W-1:0] in_take,
    input logic              mseq_start,
    input logic              mseq_ready,
    input logic              busy,
    input logic [DRAIN-1:0]  out_valid,
    input logic [OCC_W-1:0]  occ
);
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);
    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> in_take == '0);
    // R4
    start_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mseq_start |-> (int'(in_take) == 1 && !busy));
    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mseq_start |=> busy);
    // R8
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mseq_ready |-> (busy && int'(occ) < DEPTH));
    // R3
    take_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(in_take) <= $countones(in_valid));
    // R9
    head_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid[0] |-> (out_valid == '0 && occ == '0));
endmodule

bind uq_steer_queue uq_chk #(.NSLOT(NSLOT), .DEPTH(DEPTH), .DRAIN(DRAIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_take(in_take),
    .mseq_start(mseq_start), .mseq_ready(mseq_ready), .busy(busy),
    .out_valid(out_valid), .occ(occ)
);

// File: tb/tb_uq_steer_queue.sv
// Bench for uq_steer_queue: behavioural reference queue compared every cycle.
module tb_uq_steer_queue;
    import uq_pkg::*;
    localparam int NSLOT = 3, MAXU = 4, CNT_W = 3, DEPTH = 6, DRAIN = 3;
    localparam int NINST = 320;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                        rst_n;
    logic [NSLOT-1:0]            in_valid;
    logic [NSLOT*CNT_W-1:0]      in_cnt;
    logic [NSLOT*MAXU*UOP_W-1:0] in_uops;
    logic [1:0]                  in_take;
    logic                        mseq_start;
    logic [OPC_W-1:0]            mseq_entry;
    logic                        mseq_valid;
    logic [UOP_W-1:0]            mseq_uop;
    logic                        mseq_last;
    logic                        mseq_ready;
    logic [DRAIN-1:0]            out_valid;
    logic [DRAIN*UOP_W-1:0]      out_uops;
    logic [1:0]                  rn_pop;

    uq_steer_queue dut (.*);

    int checks = 0, fails = 0;
    bit done = 0;
    int icnt [NINST];
    uop_t mq [$];
    bit m_busy = 0;
    int seq_id = 0, seq_left = 0, seq_k = 0, pos = 0;

    function automatic uop_t mk(int id, int k);
        uop_t u;
        u.opc   = 8'(id * 5 + k * 61 + 3);
        u.dst   = 32'(id * 16 + k);
        u.src_a = 32'(id) ^ 32'h5a5a_0000 ^ 32'(k << 8);
        u.src_b = ~32'(id * 3 + k);
        return u;
    endfunction

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // One cycle: drive, compare against the reference, then advance it.
    task automatic step(int pop_max, int mv_prob);
        uop_t wq [$];
        int free, e_take, lim;
        bit e_start, e_ready, acc, ovf, r5;
        string tg;
        @(negedge clk);
        for (int s = 0; s < NSLOT; s++) begin
            int idx = pos + s;
            in_valid[s] = idx < NINST;
            in_cnt[s*CNT_W +: CNT_W] = idx < NINST ? CNT_W'(icnt[idx]) : '0;
            for (int k = 0; k < MAXU; k++)
                in_uops[(s*MAXU+k)*UOP_W +: UOP_W] = idx < NINST ? mk(idx, k) : '0;
        end
        mseq_valid = (seq_left > 0) && (($urandom % 100) < mv_prob);
        mseq_uop   = mk(1000 + seq_id, seq_k);
        mseq_last  = mseq_valid && seq_left == 1;
        lim = mq.size() < DRAIN ? mq.size() : DRAIN;
        rn_pop = 2'(($urandom % (pop_max + 1)) < lim ? ($urandom % (pop_max + 1)) : lim);
        if (int'(rn_pop) > lim) rn_pop = 2'(lim);
        #1;
        free = DEPTH - mq.size();
        e_take = 0; e_start = 0; ovf = 0; r5 = 0;
        e_ready = m_busy && free >= 1;
        acc = mseq_valid && e_ready;
        if (m_busy) begin
            if (acc) wq.push_back(mseq_uop);
        end else if (pos < NINST) begin
            if (icnt[pos] > MAXU) begin
                e_take = 1; e_start = 1;
            end else begin
                for (int k = 0; k < icnt[pos]; k++) wq.push_back(mk(pos, k));
                e_take = 1;
                for (int s = 1; s < NSLOT; s++) begin
                    if (pos + s >= NINST) break;
                    if (icnt[pos+s] != 1) begin r5 = icnt[pos+s] > MAXU; break; end
                    wq.push_back(mk(pos + s, 0));
                    e_take++;
                end
            end
            if (wq.size() > free) begin ovf = 1; e_take = 0; e_start = 0; wq.delete(); end
        end
        tg = m_busy ? "R7" : ovf ? "R6" : r5 ? "R5" : e_start ? "R4" : "R3";
        chk(tg, "in_take", 128'(in_take), 128'(e_take));
        chk("R4", "mseq_start", 128'(mseq_start), 128'(e_start));
        if (e_start) chk("R4", "mseq_entry", 128'(mseq_entry), 128'(mk(pos, 0).opc));
        chk("R8", "mseq_ready", 128'(mseq_ready), 128'(e_ready));
        for (int i = 0; i < DRAIN; i++) begin
            chk("R9", "out_valid", 128'(out_valid[i]), 128'(i < mq.size()));
            if (i < mq.size())
                chk("R2", "out_uop", 128'(out_uops[i*UOP_W +: UOP_W]), 128'(mq[i]));
        end
        for (int i = 0; i < int'(rn_pop); i++) void'(mq.pop_front());
        foreach (wq[i]) mq.push_back(wq[i]);
        if (acc) begin
            seq_k++; seq_left--;
            if (seq_left == 0) m_busy = 0;
        end
        if (e_start) begin
            m_busy = 1; seq_id = pos; seq_left = icnt[pos]; seq_k = 0;
        end
        pos += e_take;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int pre [16] = '{1,1,1, 3,1,1, 1,2,1, 1,6, 7, 4,4, 1,5};
        int cyc;
        foreach (pre[i]) icnt[i] = pre[i];
        for (int i = 16; i < NINST; i++) begin
            int r = $urandom % 10;
            icnt[i] = r < 6 ? 1 : r < 8 ? 2 + ($urandom % 3) : 5 + ($urandom % 3);
        end
        rst_n = 0; in_valid = '0; in_cnt = '0; in_uops = '0;
        mseq_valid = 0; mseq_uop = '0; mseq_last = 0; rn_pop = '0;
        repeat (3) @(negedge clk);
        // R1: queue empty and sequencer idle under reset
        chk("R1", "out_valid in reset", 128'(out_valid), 128'(0));
        chk("R1", "mseq_ready in reset", 128'(mseq_ready), 128'(0));
        rst_n = 1;
        #1;
        chk("R1", "out_valid after reset", 128'(out_valid), 128'(0));
        cyc = 0;
        while ((pos < NINST || m_busy || mq.size() > 0) && cyc < 20000) begin
            int pm = (cyc >= 60 && cyc < 80) ? 0 : ((cyc / 50) % 2 == 0) ? 3 : 1;
            step(pm, 70);
            cyc++;
        end
        if (cyc >= 20000) begin
            fails++;
            $display("FAIL watchdog: actual stuck expected drained");
        end
        finish_run();
    end
endmodule